// File: doc/BRIEF.md
# Peripheral-to-Memory Byte DMA Channel

This block is a single-channel engine that drains bytes from a disk controller into system memory. Software loads a destination address and a byte count through a small word-indexed register port, then the peripheral raises its data request line. While the request stays high and bytes remain, the engine moves one byte per clock. Each move strobes the peripheral for a byte, writes it to memory at the current address, then steps the address up and the count down.

When the count has run out, the engine gives the peripheral a one-cycle terminal-count pulse in the cycle after the final byte. It never raises this pulse while a byte is still moving. If the request drops while bytes remain, the channel parks with its address and count intact and continues on the next rising request. A busy flag marks the span from the first serviced byte to the end of the terminal-count pulse.

The sequencer has four states. `ST_IDLE` is no transfer in progress. `ST_MOVE` moves bytes while the request is high. `ST_HOLD` is parked mid-transfer with bytes still owed. `ST_TERM` is the terminal-count cycle. The transitions are named as follows:

| Transition | From | To | Condition |
|---|---|---|---|
| start | IDLE | MOVE | request rises while the count is nonzero |
| pause | MOVE | HOLD | request low while bytes remain |
| resume | HOLD | MOVE | request rises again |
| last | MOVE | TERM | the final byte moves |
| finish | TERM | IDLE | always, after one cycle |
| abandon | MOVE or HOLD | IDLE | software writes the count to zero |

Top module: `fdma_channel`

## Requirements
- R1: The register port is indexed by `reg_idx`. Word 0 is the destination address, word 2 the remaining byte count and word 3 a control word, and all three read back what was written. Word 1 reads as zero, and writes to it are ignored.
- R2: After reset, the address, count and control registers read zero, and `tc`, `busy`, `mem_we` and `periph_rd` are low.
- R3: A transfer starts on a rising `drq`. The first byte moves in the cycle after the clock edge that first samples `drq` high.
- R4: In a moving cycle, `periph_rd` and `mem_we` are both high, `mem_wdata` equals `periph_data` and `mem_addr` equals the address register. At most one byte moves per clock, and exactly as many bytes move as the loaded count.
- R5: Each moved byte raises the address by one, wrapping at the address width, and lowers the count by one. After a complete transfer, the count reads zero and the address reads the start address plus the loaded count.
- R6: While `drq` is low with bytes remaining, no byte moves, the address and count hold and `busy` stays high. Moving resumes after the next rising `drq`.
- R7: `tc` is high for exactly one cycle per transfer. That cycle immediately follows the cycle that moved the last byte, and no byte moves in it.
- R8: `busy` is low in the cycle of the first byte, high from the next cycle through the `tc` cycle, and low in the cycle after `tc`.
- R9: A rising `drq` while the count is zero moves no byte, pulses no `tc` and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | 2 | Register word index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| drq | input | 1 | Peripheral data request |
| periph_rd | output | 1 | Peripheral byte read strobe |
| periph_data | input | 8 | Byte presented by the peripheral |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory byte write data |
| tc | output | 1 | Terminal-count pulse to the peripheral |
| busy | output | 1 | Transfer-in-progress flag |

## Verification
A sequencer stuck in the wrong state shows up at once at the ports. A missing or extra strobe appears within one cycle of the expected byte. A `tc` that comes early or late is off by one cycle relative to the last `mem_we`. A stale `busy` is wrong in the cycle after `tc`. Faults in the address or count datapath surface on the next moved byte as a wrong `mem_addr`, or at the end of the transfer as a wrong byte total or a wrong register readback. Sweeping every count from 1 to 8 with a pause after every possible byte exposes each transition, including pause and resume on the final byte.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MOVE,
        ST_HOLD,
        ST_TERM
    } fdma_state_e;

    localparam logic [1:0] IDX_ADDR  = 2'd0;
    localparam logic [1:0] IDX_SPARE = 2'd1;
    localparam logic [1:0] IDX_COUNT = 2'd2;
    localparam logic [1:0] IDX_CTRL  = 2'd3;

endpackage

// File: rtl/fdma_regs.sv
module fdma_regs #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic             step,
    output logic [REG_W-1:0] rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic             cnt_zero,
    output logic             cnt_one
);
    import fdma_pkg::*;

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [REG_W-1:0]  ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (step) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q - 1'b1;
            end
            if (wr_en) begin
                unique case (idx)
                    IDX_ADDR:  addr_q <= ADDR_W'(wr_data);
                    IDX_COUNT: cnt_q  <= CNT_W'(wr_data);
                    IDX_CTRL:  ctrl_q <= wr_data;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (idx)
            IDX_ADDR:  rd_data = REG_W'(addr_q);
            IDX_COUNT: rd_data = REG_W'(cnt_q);
            IDX_CTRL:  rd_data = ctrl_q;
            default:   rd_data = '0;
        endcase
    end

    assign cur_addr = addr_q;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_W'(1));

    AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en) |=> (addr_q == $past(addr_q) + 1'b1)); // R5
    AST_NO_STEP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero); // R9
    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_en) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/fdma_fsm.sv
module fdma_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic drq,
    input  logic cnt_zero,
    input  logic cnt_one,
    output logic xfer,
    output logic tc,
    output logic busy
);
    import fdma_pkg::*;

    fdma_state_e state_q, state_d;
    logic        drq_q;
    logic        active_q;
    logic        drq_rise;

    assign drq_rise = drq && !drq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            drq_q    <= 1'b0;
            active_q <= 1'b0;
        end else begin
            state_q <= state_d;
            drq_q   <= drq;
            if (state_d == ST_IDLE)
                active_q <= 1'b0;
            else if (xfer)
                active_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (drq_rise && !cnt_zero) state_d = ST_MOVE;
            ST_MOVE: begin
                if (cnt_zero)     state_d = ST_IDLE;
                else if (!drq)    state_d = ST_HOLD;
                else if (cnt_one) state_d = ST_TERM;
            end
            ST_HOLD: begin
                if (cnt_zero)      state_d = ST_IDLE;
                else if (drq_rise) state_d = ST_MOVE;
            end
            ST_TERM: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        xfer = (state_q == ST_MOVE) && drq && !cnt_zero;
        tc   = (state_q == ST_TERM);
        busy = active_q;
    end

    AST_TC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc); // R7
    AST_TC_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> ($past(xfer) && cnt_zero)); // R7
    AST_BUSY_DROPS_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !busy); // R8
    AST_BUSY_IN_TC: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> busy); // R8

endmodule

// File: rtl/fdma_channel.sv
module fdma_channel #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              drq,
    output logic              periph_rd,
    input  logic [BYTE_W-1:0] periph_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              tc,
    output logic              busy
);

    logic xfer;
    logic cnt_zero;
    logic cnt_one;

    fdma_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .REG_W  (REG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .idx      (reg_idx),
        .wr_data  (reg_wdata),
        .step     (xfer),
        .rd_data  (reg_rdata),
        .cur_addr (mem_addr),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    fdma_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .drq      (drq),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .xfer     (xfer),
        .tc       (tc),
        .busy     (busy)
    );

    assign periph_rd = xfer;
    assign mem_we    = xfer;
    assign mem_wdata = periph_data;

    AST_NO_MOVE_WITHOUT_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> drq); // R6
    AST_NO_MOVE_IN_TC: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> !periph_rd); // R7

endmodule

// File: tb/fdma_channel_test.sv
module fdma_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        drq = 1'b0;
    logic        periph_rd;
    logic [7:0]  periph_data;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        tc;
    logic        busy;

    int tests = 0;
    int fails = 0;
    logic [7:0] src = 8'h11;
    logic [7:0] exp_data = 8'h11;

    always #2 clk = ~clk;

    fdma_channel uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drq(drq),
        .periph_rd(periph_rd), .periph_data(periph_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tc(tc), .busy(busy)
    );

    assign periph_data = src;
    always @(posedge clk) if (periph_rd) src <= src + 8'd37;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] idx, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] idx, output logic [31:0] d);
        reg_idx = idx;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic run_case(input logic [31:0] a, input int n, input int p);
        int writes = 0, first = -1, last = -1, tc_n = 0, tc_cyc = -1;
        int bad_addr = 0, bad_data = 0, bad_busy = 0, overlap = 0, hold_moves = 0;
        bit paused = 0;
        logic [31:0] rv;
        reg_write(2'd0, a);
        reg_write(2'd2, n);
        @(posedge clk); #1 drq = 1'b1;
        for (int cyc = 0; cyc < n + 30; cyc++) begin
            @(negedge clk);
            if (mem_we) begin
                if (first < 0) begin
                    first = cyc;
                    if (busy) bad_busy++;
                end
                if (mem_addr != a + writes || !periph_rd) bad_addr++;
                if (mem_wdata != exp_data) bad_data++;
                exp_data = exp_data + 8'd37;
                writes++;
                last = cyc;
                if (tc) overlap++;
            end
            if (first >= 0 && cyc == first + 1 && !busy) bad_busy++;
            if (tc) begin
                tc_n++; tc_cyc = cyc;
                if (!busy) bad_busy++;
            end
            if (tc_cyc >= 0 && cyc == tc_cyc + 1 && busy) bad_busy++;
            if (p != 0 && writes == p && !paused) begin
                paused = 1;
                @(posedge clk); #1 drq = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    if (mem_we || tc) hold_moves++;
                    if (!busy) bad_busy++;
                end
                reg_read(2'd2, rv);
                check(rv == n - p, "R6 count held", rv, n - p);
                reg_read(2'd0, rv);
                check(rv == a + p, "R6 address held", rv, a + p);
                @(posedge clk); #1 drq = 1'b1;
            end
        end
        drq = 1'b0;
        check(first == 1, "R3 first byte timing", first, 1);
        check(writes == n, "R4 byte total", writes, n);
        check(bad_addr == 0, "R4 address/strobe", bad_addr, 0);
        check(bad_data == 0, "R4 data", bad_data, 0);
        check(tc_n == 1, "R7 tc pulse count", tc_n, 1);
        check(tc_cyc == last + 1, "R7 tc follows last byte", tc_cyc, last + 1);
        check(overlap == 0, "R7 tc with byte", overlap, 0);
        check(bad_busy == 0, "R8 busy window", bad_busy, 0);
        check(hold_moves == 0, "R6 no move while parked", hold_moves, 0);
        reg_read(2'd2, rv);
        check(rv == 0, "R5 final count", rv, 0);
        reg_read(2'd0, rv);
        check(rv == a + n, "R5 final address", rv, a + n);
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int zero_moves;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R2: reset state
        @(negedge clk);
        check(!tc && !busy && !mem_we && !periph_rd, "R2 outputs", {tc, busy, mem_we, periph_rd}, 0);
        for (int i = 0; i < 4; i++) begin
            reg_read(2'(i), rv);
            check(rv == 0, "R2 register", rv, 0);
        end
        // R1: register map
        reg_write(2'd3, 32'hC0DE_0042);
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_write(2'd0, 32'h0000_BEEF);
        reg_read(2'd3, rv); check(rv == 32'hC0DE_0042, "R1 control", rv, 32'hC0DE_0042);
        reg_read(2'd1, rv); check(rv == 0, "R1 word1 reads zero", rv, 0);
        reg_read(2'd0, rv); check(rv == 32'h0000_BEEF, "R1 address", rv, 32'h0000_BEEF);
        reg_read(2'd2, rv); check(rv == 0, "R1 count untouched", rv, 0);
        // R9: request with zero count
        @(posedge clk); #1 drq = 1'b1;
        zero_moves = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (mem_we || tc || busy) zero_moves++;
        end
        drq = 1'b0;
        check(zero_moves == 0, "R9 zero count idle", zero_moves, 0);
        // sweep counts and pause points
        for (int n = 1; n <= 8; n++)
            for (int p = 0; p < n; p++)
                run_case(32'h1000_0000 + 32'(n * 256 + p * 16), n, p);
        // R5: address wrap
        run_case(32'hFFFF_FFFE, 4, 0);
        run_case(32'hFFFF_FFFF, 3, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule